// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Peripheral Takeover

This block is a 32-pin general-purpose I/O port. Software controls it through a small word-indexed register bus. The registers are:

- an output-value register, with bit-set and bit-clear aliases;
- a direction register, also with set and clear aliases;
- a read-only sampled-input register;
- one configuration word per pin.

From these registers and from the external pad levels, the block computes the level each pin drives, the pin's output enable, and the sampled input value.

Any other on-chip peripheral can claim parts of a pin through a one-cycle request. It can claim the output value, the direction, or the input-buffer connection, each on its own. A claim made on one of these leaves the other two with the port registers. While a peripheral owns the output value, the value it supplies on a per-pin vector replaces the output register bit.

Consumers of the input are told of every change in the sampled input through a one-cycle change pulse per pin. An external level applied to a pin that the chip is driving does not reach that pin. The block raises a per-pin conflict flag instead.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the output and direction registers read 0, every configuration word reads 0x2 (input, buffer disconnected), IN reads 0 and no pad is driven.
- R2: Writing word 1 ORs the written mask into the output register, and writing word 2 clears the written bits. Word 0 writes or reads the output register directly. Reading word 1 returns the output register, and reading word 2 returns 0.
- R3: Words 5 and 6 set and clear bits of the direction register (word 4) in the same way as R2 does for the output register. Reading word 5 returns the direction register, and reading word 6 returns 0.
- R4: Configuration word 32+n holds pin n's direction in bit 0 and its input disconnect in bit 1 (1 = disconnected). Bit 0 always reads the direction register bit. Writing bit 0 changes that direction register bit.
- R5: A pin's effective direction is the peripheral-supplied direction while the peripheral owns the direction, and the direction register bit otherwise.
- R6: A pin's effective output is the peripheral value `peri_out` while the peripheral owns the output, and the output register bit otherwise. `pad_oe` is the effective direction, and `pad_out` is the effective direction AND the effective output.
- R7: IN is the pin level ANDed with the input enable. The input enable is the inverse of configuration bit 1, or the peripheral's connect flag while the peripheral owns the input. The pin level is the effective output on driven pins, and otherwise `ext_lvl` where `ext_drv` is set and 0 elsewhere.
- R8: The request codes for direction and for input are: 00 returns control to the port, 01 leaves the setting unchanged, 10 takes control and disconnects, and 11 takes control and connects. For the output value, 00 releases, 01 leaves unchanged, and 1x takes control.
- R9: An external level on a pin whose effective direction is output has no effect on IN. The pin's `ext_conflict` bit is set one cycle later.
- R10: Clearing the direction of a pin that drives high with no external drive makes the pin level low. IN then reads 0 for that pin.
- R11: Register writes and requests change `pad_out` and `pad_oe` in the cycle after the strobe. IN follows pad and configuration changes one clock later.
- R12: `in_chg` pulses for one cycle on exactly the bits of IN that changed at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| req_vld | input | 1 | Peripheral control request strobe |
| req_pin | input | 5 | Pin addressed by the request |
| req_out_ctl | input | 2 | Output ownership code |
| req_dir_ctl | input | 2 | Direction ownership code |
| req_in_ctl | input | 2 | Input ownership code |
| peri_out | input | 32 | Peripheral-supplied output values |
| ext_drv | input | 32 | External driver active per pin |
| ext_lvl | input | 32 | External level per pin |
| pad_out | output | 32 | Level driven on each pin |
| pad_oe | output | 32 | Output enable per pin |
| pin_in | output | 32 | Sampled input (IN) |
| in_chg | output | 32 | One-cycle pulse per toggled IN bit |
| ext_conflict | output | 32 | External drive met an output pin |

## Verification
`pad_out` and `pad_oe` come from registers, so they are due one clock after a write or request strobe. The bench samples them at the falling edge that follows that clock.

IN, `in_chg` and `ext_conflict` pass through one more register. The bench waits one further falling edge before reading them. It also checks that IN has not yet moved one edge earlier.

Every input change is applied at a falling edge, and every result is sampled at a falling edge. No value is taken at the active edge.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int REG_OUT    = 0;
  localparam int REG_OUTSET = 1;
  localparam int REG_OUTCLR = 2;
  localparam int REG_IN     = 3;
  localparam int REG_DIR    = 4;
  localparam int REG_DIRSET = 5;
  localparam int REG_DIRCLR = 6;
  localparam int REG_CFG0   = 32;

  typedef enum logic [1:0] {
    CTL_RELEASE  = 2'b00,
    CTL_KEEP     = 2'b01,
    CTL_TAKE_OFF = 2'b10,
    CTL_TAKE_ON  = 2'b11
  } ctl_code_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  in_val,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  indis_q
);
  localparam int PW = $clog2(NPINS);

  logic [NPINS-1:0]  out_d, dir_d, indis_d, wmask;
  logic [ADDR_W-1:0] cfg_off;
  logic [PW-1:0]     pin_idx;
  logic              is_cfg;

  assign wmask   = bus_wdata[NPINS-1:0];
  assign cfg_off = bus_addr - ADDR_W'(REG_CFG0);
  assign is_cfg  = (bus_addr >= ADDR_W'(REG_CFG0)) && (cfg_off < ADDR_W'(NPINS));
  assign pin_idx = cfg_off[PW-1:0];
  wire unused_cfg_hi = ^cfg_off[ADDR_W-1:PW];

  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    indis_d = indis_q;
    if (is_cfg) begin
      dir_d[pin_idx]   = bus_wdata[0];
      indis_d[pin_idx] = bus_wdata[1];
    end else begin
      case (bus_addr)
        ADDR_W'(REG_OUT):    out_d = wmask;
        ADDR_W'(REG_OUTSET): out_d = out_q | wmask;
        ADDR_W'(REG_OUTCLR): out_d = out_q & ~wmask;
        ADDR_W'(REG_DIR):    dir_d = wmask;
        ADDR_W'(REG_DIRSET): dir_d = dir_q | wmask;
        ADDR_W'(REG_DIRCLR): dir_d = dir_q & ~wmask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      indis_q <= '1;
    end else if (bus_we) begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      indis_q <= indis_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_cfg) begin
      bus_rdata[1:0] = {indis_q[pin_idx], dir_q[pin_idx]};
    end else begin
      case (bus_addr)
        ADDR_W'(REG_OUT), ADDR_W'(REG_OUTSET): bus_rdata[NPINS-1:0] = out_q;
        ADDR_W'(REG_DIR), ADDR_W'(REG_DIRSET): bus_rdata[NPINS-1:0] = dir_q;
        ADDR_W'(REG_IN):                       bus_rdata[NPINS-1:0] = in_val;
        default: ;
      endcase
    end
  end

  assert_outset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(REG_OUTSET)
    |=> (out_q & $past(wmask)) == $past(wmask));
  assert_outclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(REG_OUTCLR)
    |=> (out_q & $past(wmask)) == '0);
  assert_dirclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(REG_DIRCLR)
    |=> (dir_q & $past(wmask)) == '0);
  assert_cfg_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && is_cfg |=> dir_q[$past(pin_idx)] == $past(bus_wdata[0]));
endmodule

// File: rtl/gpio_ovr_owner.sv
module gpio_ovr_owner
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int PW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [PW-1:0]    req_pin,
  input  logic [1:0]       req_out_ctl,
  input  logic [1:0]       req_dir_ctl,
  input  logic [1:0]       req_in_ctl,
  output logic [NPINS-1:0] out_own,
  output logic [NPINS-1:0] dir_own,
  output logic [NPINS-1:0] dir_set,
  output logic [NPINS-1:0] in_own,
  output logic [NPINS-1:0] in_conn
);
  logic [NPINS-1:0] out_own_d, dir_own_d, dir_set_d, in_own_d, in_conn_d;

  always_comb begin
    out_own_d = out_own;
    dir_own_d = dir_own;
    dir_set_d = dir_set;
    in_own_d  = in_own;
    in_conn_d = in_conn;
    case (req_out_ctl)
      CTL_RELEASE: out_own_d[req_pin] = 1'b0;
      CTL_KEEP:    ;
      default:     out_own_d[req_pin] = 1'b1;
    endcase
    if (req_dir_ctl != CTL_KEEP) begin
      dir_own_d[req_pin] = req_dir_ctl[1];
      dir_set_d[req_pin] = (req_dir_ctl == CTL_TAKE_ON);
    end
    if (req_in_ctl != CTL_KEEP) begin
      in_own_d[req_pin]  = req_in_ctl[1];
      in_conn_d[req_pin] = (req_in_ctl == CTL_TAKE_ON);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_own <= '0;
      dir_own <= '0;
      dir_set <= '0;
      in_own  <= '0;
      in_conn <= '0;
    end else if (req_vld) begin
      out_own <= out_own_d;
      dir_own <= dir_own_d;
      dir_set <= dir_set_d;
      in_own  <= in_own_d;
      in_conn <= in_conn_d;
    end
  end

  assert_in_take_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_in_ctl == CTL_TAKE_ON
    |=> in_own[$past(req_pin)] && in_conn[$past(req_pin)]);
  assert_dir_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_dir_ctl == CTL_RELEASE |=> !dir_own[$past(req_pin)]);
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_out_ctl == CTL_KEEP && req_dir_ctl == CTL_KEEP && req_in_ctl == CTL_KEEP
    |=> $stable(out_own) && $stable(dir_own) && $stable(in_own));
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] indis_q,
  input  logic [NPINS-1:0] out_own,
  input  logic [NPINS-1:0] dir_own,
  input  logic [NPINS-1:0] dir_set,
  input  logic [NPINS-1:0] in_own,
  input  logic [NPINS-1:0] in_conn,
  input  logic [NPINS-1:0] peri_out,
  input  logic [NPINS-1:0] ext_drv,
  input  logic [NPINS-1:0] ext_lvl,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pin_lvl,
  output logic [NPINS-1:0] in_en,
  output logic [NPINS-1:0] clash
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic dir_eff, out_eff;
    assign dir_eff    = dir_own[n] ? dir_set[n]  : dir_q[n];
    assign out_eff    = out_own[n] ? peri_out[n] : out_q[n];
    assign pad_oe[n]  = dir_eff;
    assign pad_out[n] = dir_eff & out_eff;
    assign in_en[n]   = in_own[n] ? in_conn[n] : ~indis_q[n];
    assign pin_lvl[n] = dir_eff ? out_eff : (ext_drv[n] & ext_lvl[n]);
    assign clash[n]   = dir_eff & ext_drv[n];
  end
endmodule

// File: rtl/gpio_ovr_sample.sv
module gpio_ovr_sample #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] in_en,
  input  logic [NPINS-1:0] clash,
  output logic [NPINS-1:0] in_q,
  output logic [NPINS-1:0] in_chg,
  output logic [NPINS-1:0] ext_conflict
);
  logic [NPINS-1:0] in_d, chg_d;

  always_comb begin
    in_d  = pin_lvl & in_en;
    chg_d = in_d ^ in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q         <= '0;
      in_chg       <= '0;
      ext_conflict <= '0;
    end else begin
      in_q         <= in_d;
      in_chg       <= chg_d;
      ext_conflict <= clash;
    end
  end

  assert_in_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_q & ~$past(in_en)) == '0);
  assert_chg_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_chg == (in_q ^ $past(in_q)));
  assert_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ext_conflict & ~$past(pad_drive_check(clash))) == '0);

  function automatic logic [NPINS-1:0] pad_drive_check(input logic [NPINS-1:0] v);
    return v;
  endfunction
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int DW     = 32,
  localparam int PW = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              req_vld,
  input  logic [PW-1:0]     req_pin,
  input  logic [1:0]        req_out_ctl,
  input  logic [1:0]        req_dir_ctl,
  input  logic [1:0]        req_in_ctl,
  input  logic [NPINS-1:0]  peri_out,
  input  logic [NPINS-1:0]  ext_drv,
  input  logic [NPINS-1:0]  ext_lvl,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  in_chg,
  output logic [NPINS-1:0]  ext_conflict
);
  logic [NPINS-1:0] out_q, dir_q, indis_q;
  logic [NPINS-1:0] out_own, dir_own, dir_set, in_own, in_conn;
  logic [NPINS-1:0] pin_lvl, in_en, clash;

  gpio_ovr_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_val(pin_in),
    .out_q(out_q), .dir_q(dir_q), .indis_q(indis_q)
  );

  gpio_ovr_owner #(.NPINS(NPINS)) u_owner (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pin(req_pin),
    .req_out_ctl(req_out_ctl), .req_dir_ctl(req_dir_ctl), .req_in_ctl(req_in_ctl),
    .out_own(out_own), .dir_own(dir_own), .dir_set(dir_set),
    .in_own(in_own), .in_conn(in_conn)
  );

  gpio_ovr_pinmux #(.NPINS(NPINS)) u_pinmux (
    .out_q(out_q), .dir_q(dir_q), .indis_q(indis_q),
    .out_own(out_own), .dir_own(dir_own), .dir_set(dir_set),
    .in_own(in_own), .in_conn(in_conn), .peri_out(peri_out),
    .ext_drv(ext_drv), .ext_lvl(ext_lvl), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_lvl(pin_lvl), .in_en(in_en), .clash(clash)
  );

  gpio_ovr_sample #(.NPINS(NPINS)) u_sample (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .in_en(in_en), .clash(clash),
    .in_q(pin_in), .in_chg(in_chg), .ext_conflict(ext_conflict)
  );

  assert_undriven_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_in & $past(pad_oe) & ~$past(pad_out)) == '0);
  assert_write_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(4) |=> pad_oe == ($past(bus_wdata[NPINS-1:0]) & ~dir_own
                                                    | dir_own & dir_set));
endmodule

// File: tb/test_gpio_ovr_port.sv
module test_gpio_ovr_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_OUT = 6'd0, A_OUTSET = 6'd1, A_OUTCLR = 6'd2, A_IN = 6'd3,
                         A_DIR = 6'd4, A_DIRSET = 6'd5, A_DIRCLR = 6'd6, A_CFG = 6'd32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_vld = 1'b0;
  logic [4:0]  req_pin = '0;
  logic [1:0]  req_out_ctl = 2'b01, req_dir_ctl = 2'b01, req_in_ctl = 2'b01;
  logic [31:0] peri_out = '0, ext_drv = '0, ext_lvl = '0;
  logic [31:0] pad_out, pad_oe, pin_in, in_chg, ext_conflict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port i_gpio_ovr_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_vld(req_vld),
    .req_pin(req_pin), .req_out_ctl(req_out_ctl), .req_dir_ctl(req_dir_ctl),
    .req_in_ctl(req_in_ctl), .peri_out(peri_out), .ext_drv(ext_drv),
    .ext_lvl(ext_lvl), .pad_out(pad_out), .pad_oe(pad_oe), .pin_in(pin_in),
    .in_chg(in_chg), .ext_conflict(ext_conflict)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic req(input logic [4:0] p, input logic [1:0] oc, input logic [1:0] dc,
                     input logic [1:0] ic);
    @(negedge clk);
    req_vld = 1'b1; req_pin = p; req_out_ctl = oc; req_dir_ctl = dc; req_in_ctl = ic;
    @(negedge clk);
    req_vld = 1'b0; req_out_ctl = 2'b01; req_dir_ctl = 2'b01; req_in_ctl = 2'b01;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_OUT, v);       chk("R1 out", v, 32'h0);
    rd(A_DIR, v);       chk("R1 dir", v, 32'h0);
    rd(A_CFG, v);       chk("R1 cfg0", v, 32'h2);
    rd(A_CFG + 6'd31, v); chk("R1 cfg31", v, 32'h2);
    rd(A_IN, v);        chk("R1 in", v, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_out_setclr();
    logic [31:0] v;
    wr(A_OUTSET, 32'h0000_00F0);
    rd(A_OUT, v);    chk("R2 outset", v, 32'h0000_00F0);
    rd(A_OUTSET, v); chk("R2 outset read", v, 32'h0000_00F0);
    wr(A_OUTCLR, 32'h0000_0030);
    rd(A_OUT, v);    chk("R2 outclr", v, 32'h0000_00C0);
    rd(A_OUTCLR, v); chk("R2 outclr read", v, 32'h0);
    wr(A_OUT, 32'h1234_5678);
    rd(A_OUT, v);    chk("R2 out write", v, 32'h1234_5678);
    wr(A_OUT, 32'h0000_00A5);
  endtask

  task automatic t_dir_setclr();
    logic [31:0] v;
    wr(A_DIRSET, 32'h0000_000F);
    chk("R11 pad_oe next cycle", pad_oe, 32'h0000_000F);
    chk("R6 pad_out", pad_out, 32'h0000_0005);
    rd(A_DIRSET, v); chk("R3 dirset read", v, 32'h0000_000F);
    wr(A_DIRCLR, 32'h0000_0003);
    rd(A_DIR, v);    chk("R3 dirclr", v, 32'h0000_000C);
    rd(A_DIRCLR, v); chk("R3 dirclr read", v, 32'h0);
    chk("R6 pad_out after clr", pad_out, 32'h0000_0004);
  endtask

  task automatic t_cfg_mirror();
    logic [31:0] v;
    rd(A_CFG + 6'd2, v); chk("R4 cfg mirrors dir", v, 32'h3);
    wr(A_CFG + 6'd5, 32'h1);
    rd(A_DIR, v);        chk("R4 cfg sets dir", v, 32'h0000_002C);
    rd(A_CFG + 6'd5, v); chk("R4 cfg read", v, 32'h1);
    wr(A_CFG + 6'd5, 32'h2);
    rd(A_DIR, v);        chk("R4 cfg clears dir", v, 32'h0000_000C);
    wr(A_DIR, 32'h0);
    rd(A_CFG + 6'd2, v); chk("R4 dir write mirrors", v, 32'h2);
  endtask

  task automatic t_input();
    logic [31:0] v;
    ext_drv = 32'hFFFF_FFFF; ext_lvl = 32'hFFFF_0000;
    step(); step();
    rd(A_IN, v); chk("R7 disconnected", v, 32'h0);
    wr(A_CFG + 6'd16, 32'h0);
    rd(A_IN, v); chk("R11 IN one clock later", v, 32'h0);
    step();
    rd(A_IN, v); chk("R7 connected", v, 32'h0001_0000);
    chk("R12 chg rise", in_chg, 32'h0001_0000);
    step();
    chk("R12 chg one cycle", in_chg, 32'h0);
    ext_lvl[16] = 1'b0;
    step();
    chk("R11 IN pad change", pin_in, 32'h0);
    chk("R12 chg fall", in_chg, 32'h0001_0000);
  endtask

  task automatic t_override();
    logic [31:0] v;
    peri_out = 32'hFFFF_FFFF;
    req(5'd1, 2'b10, 2'b11, 2'b01);
    chk("R5 dir taken", pad_oe & 32'h2, 32'h2);
    chk("R6 peri value", pad_out & 32'h2, 32'h2);
    req(5'd1, 2'b01, 2'b01, 2'b01);
    chk("R8 keep", pad_oe & 32'h2, 32'h2);
    wr(A_DIRSET, 32'h2);
    req(5'd1, 2'b01, 2'b10, 2'b01);
    chk("R5 take disconnect", pad_oe & 32'h2, 32'h0);
    req(5'd1, 2'b00, 2'b01, 2'b01);
    req(5'd1, 2'b01, 2'b00, 2'b01);
    chk("R8 dir release", pad_oe & 32'h2, 32'h2);
    chk("R6 out release", pad_out & 32'h2, 32'h0);
    wr(A_DIRCLR, 32'h2);
    ext_drv = 32'h0010_0000; ext_lvl = 32'h0010_0000;
    req(5'd20, 2'b01, 2'b01, 2'b11);
    step();
    rd(A_IN, v); chk("R8 in take connect", v & 32'h0010_0000, 32'h0010_0000);
    req(5'd20, 2'b01, 2'b01, 2'b10);
    step();
    rd(A_IN, v); chk("R8 in take disconnect", v & 32'h0010_0000, 32'h0);
    req(5'd20, 2'b01, 2'b01, 2'b00);
    step();
    rd(A_IN, v); chk("R7 released to cfg", v & 32'h0010_0000, 32'h0);
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    ext_drv = 32'h0000_0100; ext_lvl = 32'h0000_0100;
    wr(A_CFG + 6'd8, 32'h1);
    step();
    rd(A_IN, v); chk("R9 ext ignored", v & 32'h100, 32'h0);
    chk("R9 conflict flag", ext_conflict, 32'h0000_0100);
    chk("R9 pad_out", pad_out & 32'h100, 32'h0);
    wr(A_DIRCLR, 32'h100);
    step();
    rd(A_IN, v); chk("R9 ext seen as input", v & 32'h100, 32'h100);
    chk("R9 conflict clear", ext_conflict, 32'h0);
  endtask

  task automatic t_dropdir();
    logic [31:0] v;
    ext_drv = 32'h0;
    wr(A_OUTSET, 32'h200);
    wr(A_CFG + 6'd9, 32'h1);
    step();
    rd(A_IN, v); chk("R10 driven high", v & 32'h200, 32'h200);
    wr(A_DIRCLR, 32'h200);
    chk("R10 pad released", pad_oe & 32'h200, 32'h0);
    step();
    rd(A_IN, v); chk("R10 level low", v & 32'h200, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_out_setclr();
    t_dir_setclr();
    t_cfg_mirror();
    t_input();
    t_override();
    t_conflict();
    t_dropdir();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule